// File: doc/BRIEF.md
# XOR-Swizzled Banked Scratchpad

This block stores a square matrix of 32-bit words across a set of independent single-port banks. The default is a 32 by 32 matrix in 32 banks. One request moves one word per lane on 32 lanes at once.

A request names one of three access shapes:
- **Row sweep:** every element of one matrix row.
- **Column sweep:** every element of one matrix column.
- **Gather:** each lane carries its own row/column coordinate.

Each lane has an enable. A request either writes all of its enabled lanes or reads all of them.

By default, element (r, c) lives in bank `r ^ c` at bank word r. With this placement, a row sweep and a column sweep each visit every bank exactly once, so either one finishes in a single issue cycle. A per-request flag selects plain placement instead, where the bank is simply c. Under plain placement a column sweep lands entirely in one bank and costs one issue cycle per element. The flag exists so the two placements can be compared.

Gather requests, and any sweep under plain placement, are serialized by a per-bank scheduler. In each issue cycle, every bank serves the lowest-numbered enabled lane that is still waiting on it. The number of issue cycles therefore equals the largest count of enabled lanes that share one bank.

Reads are returned together on a wide result bus, marked by a one-cycle completion pulse.

Top module: `xor_scratchpad`

## Requirements
- R1: While reset is high, and on the first cycle after it, `busy` and `done` are 0 and `rd_data` is all zero.
- R2: Row mode gives lane l element (`req_index`, l). With swizzle on, `busy` is high for exactly 2 cycles after acceptance, and `done` follows immediately.
- R3: Column mode gives lane l element (l, `req_index`). With swizzle on, `busy` is high for exactly 2 cycles after acceptance.
- R4: Bank placement:
  - With `req_swz`=1, element (r, c) is held in bank `r^c` at bank word r.
  - With `req_swz`=0, the bank is c.
  - So data written swizzled at (r, c) reads back unswizzled at (r, `r^c`).
- R5: An unswizzled column sweep with all lanes enabled keeps `busy` high for 33 cycles.
- R6: Gather mode (`req_mode`=2 or 3) takes lane l's coordinate from `req_addr[l*10 +: 10]`, with the row in the upper 5 bits and the column in the lower 5. `busy` stays high for N+1 cycles, where N is the largest number of enabled lanes mapping to one bank, and N is at least 1.
- R7: When several enabled lanes of one write request target the same element, that element ends up holding the data of the highest-numbered such lane.
- R8: Lane enables (`req_en`):
  - A write changes only elements addressed by enabled lanes.
  - A read returns the stored word on enabled lanes and 0 on disabled lanes.
  - `rd_data` is all zero after a write completes.
- R9: A request is accepted only while `busy` is low. A request presented while `busy` is high changes no stored element and does not change the running request's length.
- R10: `done` is high for exactly one cycle, the cycle after `busy`'s last high cycle, with `busy` low. `rd_data` then holds until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_mode | input | 2 | 0 row sweep, 1 column sweep, 2/3 gather |
| req_write | input | 1 | 1 write, 0 read |
| req_swz | input | 1 | 1 XOR-swizzled placement, 0 plain placement |
| req_index | input | 5 | Row number (row mode) or column number (column mode) |
| req_addr | input | 320 | Per-lane {row, col} coordinates for gather mode |
| req_en | input | 32 | Per-lane enable |
| req_wdata | input | 1024 | Per-lane write data, lane l at bits [l*32 +: 32] |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 1024 | Per-lane read result, lane l at bits [l*32 +: 32] |

## Verification
Two things can fall in the same cycle: a fresh request arriving at the ports, and the serialized issue of a request already in flight. The bench provokes this by starting a 33-cycle unswizzled column sweep. During that sweep it holds `req_valid` high with a conflicting row write. Afterwards it judges three things: the sweep's length must be unchanged, the intruding row must still read back its earlier contents, and the sweep's own read data must match the placement model.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam logic [1:0] SP_ROW = 2'd0;
  localparam logic [1:0] SP_COL = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FLUSH = 2'd2
  } sp_state_e;
endpackage

// File: rtl/sp_lane_map.sv
// Turns a request into one (bank word, bank) pair per lane.
module sp_lane_map #(
  parameter int NB = 32,
  parameter int AW = 5
) (
  input  logic [1:0]                mode,
  input  logic [AW-1:0]             index,
  input  logic [NB-1:0][2*AW-1:0]   addr,
  input  logic                      swz,
  output logic [NB-1:0][AW-1:0]     lane_row,
  output logic [NB-1:0][AW-1:0]     lane_bank
);
  for (genvar l = 0; l < NB; l++) begin : g_lane
    logic [AW-1:0] r, c;
    always_comb begin
      case (mode)
        sp_pkg::SP_ROW: begin r = index;   c = AW'(l); end
        sp_pkg::SP_COL: begin r = AW'(l);  c = index;  end
        default:        begin r = addr[l][2*AW-1:AW]; c = addr[l][AW-1:0]; end
      endcase
    end
    assign lane_row[l]  = r;
    assign lane_bank[l] = swz ? (r ^ c) : c;
  end
endmodule

// File: rtl/sp_bank_sched.sv
// Per bank: grant the lowest-numbered pending lane aimed at it.
module sp_bank_sched #(
  parameter int NB = 32,
  parameter int AW = 5
) (
  input  logic [NB-1:0]             pending,
  input  logic [NB-1:0][AW-1:0]     lane_bank,
  output logic [NB-1:0]             grant_vld,
  output logic [NB-1:0][AW-1:0]     grant_lane,
  output logic [NB-1:0]             served
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_comb begin
      grant_vld[b]  = 1'b0;
      grant_lane[b] = '0;
      for (int l = NB - 1; l >= 0; l--) begin
        if (pending[l] && (lane_bank[l] == AW'(b))) begin
          grant_vld[b]  = 1'b1;
          grant_lane[b] = AW'(l);
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < NB; l++) begin
      served[l] = pending[l] && grant_vld[lane_bank[l]] &&
                  (grant_lane[lane_bank[l]] == AW'(l));
    end
  end
endmodule

// File: rtl/sp_bank_ram.sv
// One bank: synchronous write, registered read, no reset on storage.
module sp_bank_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/xor_scratchpad.sv
module xor_scratchpad
  import sp_pkg::*;
#(
  parameter int NB = 32,
  parameter int DW = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [1:0]                  req_mode,
  input  logic                        req_write,
  input  logic                        req_swz,
  input  logic [$clog2(NB)-1:0]       req_index,
  input  logic [NB*2*$clog2(NB)-1:0]  req_addr,
  input  logic [NB-1:0]               req_en,
  input  logic [NB*DW-1:0]            req_wdata,
  output logic                        busy,
  output logic                        done,
  output logic [NB*DW-1:0]            rd_data
);
  localparam int AW = $clog2(NB);
  localparam int LW = 2 * AW;

  logic [NB-1:0][LW-1:0] addr_2d;
  logic [NB-1:0][DW-1:0] wdata_2d;
  assign addr_2d  = req_addr;
  assign wdata_2d = req_wdata;

  sp_state_e state_q, state_d;
  logic      busy_q, done_q, op_write_q, accept, issue;

  logic [NB-1:0][AW-1:0] map_row, map_bank, row_q, bank_q;
  logic [NB-1:0][DW-1:0] wdata_q, result_q, bank_rd;
  logic [NB-1:0]         pending_q, served, grant_vld, bank_we, bank_re, ret_vld;
  logic [NB-1:0][AW-1:0] grant_lane, ret_lane;

  sp_lane_map #(.NB(NB), .AW(AW)) u_map (
    .mode      (req_mode),
    .index     (req_index),
    .addr      (addr_2d),
    .swz       (req_swz),
    .lane_row  (map_row),
    .lane_bank (map_bank)
  );

  sp_bank_sched #(.NB(NB), .AW(AW)) u_sched (
    .pending    (pending_q),
    .lane_bank  (bank_q),
    .grant_vld  (grant_vld),
    .grant_lane (grant_lane),
    .served     (served)
  );

  assign accept = (state_q == ST_IDLE) && req_valid;
  assign issue  = (state_q == ST_ISSUE);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [AW-1:0] gl;
    assign gl         = grant_lane[b];
    assign bank_we[b] = issue && grant_vld[b] && op_write_q;
    assign bank_re[b] = issue && grant_vld[b] && !op_write_q;

    sp_bank_ram #(.DW(DW), .DEPTH(NB), .AW(AW)) u_ram (
      .clk   (clk),
      .we    (bank_we[b]),
      .re    (bank_re[b]),
      .addr  (row_q[gl]),
      .wdata (wdata_q[gl]),
      .rdata (bank_rd[b])
    );
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
      ST_ISSUE: if ((pending_q & ~served) == '0) state_d = ST_FLUSH;
      ST_FLUSH: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      pending_q <= '0;
      ret_vld   <= '0;
    end else begin
      state_q <= state_d;
      busy_q  <= (state_d != ST_IDLE);
      done_q  <= (state_q == ST_FLUSH);
      ret_vld <= bank_re;
      if (accept)     pending_q <= req_en;
      else if (issue) pending_q <= pending_q & ~served;
    end
  end

  // Request payload and return tags: no reset needed.
  always_ff @(posedge clk) begin
    ret_lane <= grant_lane;
    if (accept) begin
      row_q      <= map_row;
      bank_q     <= map_bank;
      wdata_q    <= wdata_2d;
      op_write_q <= req_write;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || accept) begin
      result_q <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (ret_vld[b]) result_q[ret_lane[b]] <= bank_rd[b];
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = result_q;
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int NB = 32,
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [1:0]       req_mode,
  input logic             req_swz,
  input logic             busy,
  input logic             done,
  input logic [NB*DW-1:0] rd_data
);
  localparam int CW = $clog2(NB + 3) + 1;

  logic          rst_seen;
  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R1: outputs quiet on the cycle after a reset cycle
  always @(posedge clk) begin
    if (rst_seen === 1'b1) begin
      p_reset_quiet_r1: assert (!busy && !done && rd_data == '0);
    end
  end

  p_row_sweep_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_swz && req_mode == 2'd0)
      |=> busy ##1 busy ##1 (done && !busy));

  p_col_sweep_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_swz && req_mode == 2'd1)
      |=> busy ##1 busy ##1 (done && !busy));

  p_busy_bound_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len <= CW'(NB + 1)));

  p_done_follows_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy ##1 !done);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req_valid) |=> $stable(rd_data));
endmodule

bind xor_scratchpad sp_checker #(.NB(NB), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_mode  (req_mode),
  .req_swz   (req_swz),
  .busy      (busy),
  .done      (done),
  .rd_data   (rd_data)
);

// File: tb/tb_xor_scratchpad.sv
module tb_xor_scratchpad;
  localparam int CLK_NS = 10;
  localparam int NB = 32;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int LW = 10;

  // {mode[15:14], write[13], swz[12], index[11:7], busy_cycles[6:0]}
  localparam logic [15:0] VEC [12] = '{
    {2'd0, 1'b0, 1'b1, 5'd0,  7'd2},   // R2 row read
    {2'd0, 1'b0, 1'b1, 5'd31, 7'd2},   // R2 row read, last row
    {2'd1, 1'b0, 1'b1, 5'd0,  7'd2},   // R3 column read
    {2'd1, 1'b0, 1'b1, 5'd31, 7'd2},   // R3 column read, last column
    {2'd0, 1'b1, 1'b1, 5'd9,  7'd2},   // R2 row write
    {2'd1, 1'b0, 1'b1, 5'd4,  7'd2},   // R3 sees new row 9 data
    {2'd1, 1'b1, 1'b0, 5'd12, 7'd33},  // R5 plain column write
    {2'd0, 1'b0, 1'b0, 5'd12, 7'd2},   // R4 plain row read
    {2'd1, 1'b0, 1'b0, 5'd12, 7'd33},  // R5 plain column read
    {2'd0, 1'b0, 1'b0, 5'd5,  7'd2},   // R4 plain view of swizzled data
    {2'd1, 1'b0, 1'b1, 5'd3,  7'd2},   // R3
    {2'd0, 1'b0, 1'b1, 5'd9,  7'd2}    // R2
  };

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_swz = 1;
  logic [1:0] req_mode = 0;
  logic [AW-1:0] req_index = 0;
  logic [NB*LW-1:0] req_addr = '0;
  logic [NB-1:0] req_en = '0;
  logic [NB*DW-1:0] req_wdata = '0;
  logic busy, done;
  logic [NB*DW-1:0] rd_data;

  int checks = 0, fails = 0;
  logic [DW-1:0] phys [NB][NB];

  always #(CLK_NS/2) clk = ~clk;

  xor_scratchpad #(.NB(NB), .DW(DW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_write(req_write), .req_swz(req_swz), .req_index(req_index),
    .req_addr(req_addr), .req_en(req_en), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] pat(int r, int c);
    return {8'hC3, 3'b0, 5'(r), 3'b0, 5'(c), 8'h5A};
  endfunction

  function automatic logic [DW-1:0] dat(int seed, int l);
    return {8'(seed), 8'hE1, 3'b0, 5'(l), 8'h96};
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic chk_int(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_bus(string tag, logic [NB*DW-1:0] act, logic [NB*DW-1:0] exp);
    checks++;
    for (int l = 0; l < NB; l++) begin
      if (act[l*DW +: DW] !== exp[l*DW +: DW]) begin
        fails++;
        $display("FAIL %s lane %0d data: actual %h expected %h",
                 tag, l, act[l*DW +: DW], exp[l*DW +: DW]);
        break;
      end
    end
  endtask

  // Lane coordinates from the requirements (R2, R3, R6).
  task automatic lane_rc(logic [1:0] m, logic [AW-1:0] idx, logic [NB*LW-1:0] a,
                         int l, output int r, output int c);
    if (m == 2'd0)      begin r = idx; c = l; end
    else if (m == 2'd1) begin r = l; c = idx; end
    else begin r = a[l*LW+AW +: AW]; c = a[l*LW +: AW]; end
  endtask

  // Placement model from R4, ordering from R7, enables from R8.
  task automatic model(logic [1:0] m, logic wr, logic s, logic [AW-1:0] idx,
                       logic [NB*LW-1:0] a, logic [NB-1:0] en,
                       logic [NB*DW-1:0] wd, output logic [NB*DW-1:0] exp);
    int r, c, bk;
    exp = '0;
    for (int l = 0; l < NB; l++) begin
      if (en[l]) begin
        lane_rc(m, idx, a, l, r, c);
        bk = s ? (r ^ c) : c;
        if (wr) phys[r][bk] = wd[l*DW +: DW];
        else    exp[l*DW +: DW] = phys[r][bk];
      end
    end
  endtask

  task automatic run_req(logic [1:0] m, logic wr, logic s, logic [AW-1:0] idx,
                         logic [NB*LW-1:0] a, logic [NB-1:0] en,
                         logic [NB*DW-1:0] wd, bit intrude,
                         output int cyc, output logic [NB*DW-1:0] rd);
    @(negedge clk);
    req_mode = m; req_write = wr; req_swz = s; req_index = idx;
    req_addr = a; req_en = en; req_wdata = wd; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    cyc = 0;
    while (!done && cyc < 200) begin
      if (busy) cyc++;
      if (intrude && cyc == 2) begin
        // R9: conflicting row write while busy
        req_valid = 1; req_write = 1; req_mode = 2'd0; req_swz = 1;
        req_index = 5'd6; req_en = '1; req_wdata = '1;
      end
      if (intrude && cyc >= 10) req_valid = 0;
      @(negedge clk);
    end
    rd = rd_data;
    @(negedge clk);
    chk_int("R10", "done pulse width", int'(done), 0);
  endtask

  initial begin
    #(CLK_NS * 190000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int cyc;
    logic [NB*DW-1:0] rd, exp, wd;
    logic [NB*LW-1:0] a;
    logic [NB-1:0] en;

    repeat (4) @(negedge clk);
    chk_int("R1", "busy in reset", int'(busy), 0);
    rst = 0;
    @(negedge clk);
    chk_int("R1", "busy after reset", int'(busy), 0);
    chk_int("R1", "done after reset", int'(done), 0);
    chk_bus("R1", rd_data, '0);

    // Preload every row, swizzled.
    for (int r = 0; r < NB; r++) begin
      for (int l = 0; l < NB; l++) wd[l*DW +: DW] = pat(r, l);
      model(2'd0, 1'b1, 1'b1, AW'(r), '0, '1, wd, exp);
      run_req(2'd0, 1'b1, 1'b1, AW'(r), '0, '1, wd, 0, cyc, rd);
      chk_int("R2", "row write cycles", cyc, 2);
    end

    // Vector table walk.
    for (int i = 0; i < 12; i++) begin
      logic [15:0] v;
      string tb_tag, dtag;
      v = VEC[i];
      for (int l = 0; l < NB; l++) wd[l*DW +: DW] = dat(i + 1, l);
      tb_tag = (v[15:14] == 2'd1 && !v[12]) ? "R5" : (v[15:14] == 2'd0) ? "R2" : "R3";
      dtag = v[13] ? "R8" : (!v[12] ? "R4" : tb_tag);
      model(v[15:14], v[13], v[12], v[11:7], '0, '1, wd, exp);
      run_req(v[15:14], v[13], v[12], v[11:7], '0, '1, wd, 0, cyc, rd);
      chk_int(tb_tag, "table busy cycles", cyc, int'(v[6:0]));
      chk_bus(dtag, rd, exp);
    end

    // R6: all lanes on the diagonal -> bank 0 for every lane.
    for (int l = 0; l < NB; l++) a[l*LW +: LW] = {5'(l), 5'(l)};
    model(2'd2, 1'b0, 1'b1, '0, a, '1, '0, exp);
    run_req(2'd2, 1'b0, 1'b1, '0, a, '1, '0, 0, cyc, rd);
    chk_int("R6", "full bank conflict cycles", cyc, 33);
    chk_bus("R6", rd, exp);

    // R6: three lanes share bank 5, one lone lane, rest disabled.
    a = '0;
    a[0*LW +: LW] = {5'd0, 5'd5};
    a[1*LW +: LW] = {5'd1, 5'd4};
    a[2*LW +: LW] = {5'd2, 5'd7};
    a[10*LW +: LW] = {5'd0, 5'd10};
    en = '0; en[0] = 1; en[1] = 1; en[2] = 1; en[10] = 1;
    model(2'd3, 1'b0, 1'b1, '0, a, en, '0, exp);
    run_req(2'd3, 1'b0, 1'b1, '0, a, en, '0, 0, cyc, rd);
    chk_int("R6", "partial conflict cycles", cyc, 4);
    chk_bus("R8", rd, exp);

    // R6: no lanes enabled still takes one issue cycle.
    run_req(2'd2, 1'b0, 1'b1, '0, a, '0, '0, 0, cyc, rd);
    chk_int("R6", "empty gather cycles", cyc, 2);
    chk_bus("R8", rd, '0);

    // R7: four lanes write element (20,20); other lanes disabled.
    a = '0;
    for (int l = 0; l < 4; l++) a[l*LW +: LW] = {5'd20, 5'd20};
    for (int l = 0; l < NB; l++) wd[l*DW +: DW] = dat(77, l);
    en = 32'h0000_000F;
    model(2'd2, 1'b1, 1'b1, '0, a, en, wd, exp);
    run_req(2'd2, 1'b1, 1'b1, '0, a, en, wd, 0, cyc, rd);
    chk_int("R7", "same-element write cycles", cyc, 5);
    model(2'd0, 1'b0, 1'b1, 5'd20, '0, '1, '0, exp);
    chk_int("R7", "model winner", int'(exp[20*DW +: DW]), int'(dat(77, 3)));
    run_req(2'd0, 1'b0, 1'b1, 5'd20, '0, '1, '0, 0, cyc, rd);
    chk_bus("R7", rd, exp);

    // R9: intruding row write during a plain column sweep.
    model(2'd1, 1'b0, 1'b0, 5'd1, '0, '1, '0, exp);
    run_req(2'd1, 1'b0, 1'b0, 5'd1, '0, '1, '0, 1, cyc, rd);
    chk_int("R9", "sweep length with intruder", cyc, 33);
    chk_bus("R9", rd, exp);
    model(2'd0, 1'b0, 1'b1, 5'd6, '0, '1, '0, exp);
    run_req(2'd0, 1'b0, 1'b1, 5'd6, '0, '1, '0, 0, cyc, rd);
    chk_bus("R9", rd, exp);

    // R10: result holds while idle.
    repeat (5) @(negedge clk);
    chk_bus("R10", rd_data, rd);

    summary();
    $finish;
  end
endmodule